// File: doc/BRIEF.md
# Chip-Select Line Controller

This block drives a small set of chip-select lines from two software-visible registers. A configuration register says, for each line, whether it works as a chip select and whether its pin is inverted. The inversion is how an active-high device is served: set its inversion bit together with its chip-select enable. A second register, the force register, changes each line's internal level without a read-modify-write. Its upper half carries write-one-to-raise bits and its lower half carries write-one-to-lower bits. A high internal level means inactive and a low level means active. A status offset reads back the internal levels.

Each pin is the internal level XOR the line's inversion bit when the line is marked as a chip select. A line that is not marked drives its inversion bit alone. Writing 0x0000 to the configuration register and 0xFF00 to the force register returns every line to the inactive high internal level. Six lines are built by default, and the `NUM_LINES` parameter selects 1 to 8 lines, for example 3 for a reduced variant.

Reads pass through a two-state machine. `RD_IDLE` moves to `RD_RESP` on a read request. `RD_RESP` stays in `RD_RESP` while requests keep coming and returns to `RD_IDLE` when they stop. Read data is presented only in `RD_RESP`.

Top module: `csline_ctrl`

## Requirements
- R1: After reset the configuration reads 0x0000, the status offset reads all ones in the bits of the implemented lines, every pin is 0, and `rd_valid` is 0.
- R2: A write to offset 0 stores enable bits 8+n and inversion bits n for implemented lines. A read of offset 0 returns them in the same positions, with zeros for lines that are not implemented.
- R3: A write to offset 1 raises line n when bit 8+n is 1 and lowers line n when bit n is 1. A line whose two bits are both 0 keeps its level.
- R4: When bit 8+n and bit n are both 1 in the same force write, line n ends high.
- R5: For a line marked as a chip select, the pin equals the internal level XOR the inversion bit.
- R6: For a line not marked as a chip select, the pin equals its inversion bit, whatever the internal level.
- R7: A read of offset 2 returns the internal levels in bits [7:0], with bit n being line n, and zeros in bits [15:8].
- R8: `rd_valid` and `rd_data` appear exactly one cycle after a sampled `rd_en`. Reads of offset 1 and offset 3 return 0x0000. Back-to-back requests give back-to-back responses.
- R9: A write to offset 2 or offset 3 changes neither the levels nor the configuration.
- R10: Writes to the configuration register, and cycles with no force write, leave the internal levels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset (0 config, 1 force, 2 status) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 16 | Read data, valid with rd_valid, zero otherwise |
| rd_valid | output | 1 | Read response strobe, one cycle after rd_en |
| cs_out | output | NUM_LINES | Chip-select pins |

## Verification
The assertions check several behaviours on every cycle:
- the read handshake timing;
- the zero upper half of a status read;
- the effect of each force bit on the next-cycle level, including set winning over clear;
- level stability whenever no force write occurs.

Only the bench's scenarios can show the rest. These are the pin value produced by each combination of enable, inversion and level on every line, and the readback of the configuration. They also cover the fact that writes to the status and unmapped offsets leave everything unchanged, and the return to the all-inactive state after the restore sequence.

// File: rtl/csline_pkg.sv
package csline_pkg;

    localparam int REG_W     = 16;
    localparam int MAX_LINES = 8;

    typedef enum logic [1:0] {
        OFS_CFG   = 2'd0,
        OFS_FORCE = 2'd1,
        OFS_LEVEL = 2'd2,
        OFS_SPARE = 2'd3
    } reg_ofs_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/csline_cfg_reg.sv
module csline_cfg_reg
    import csline_pkg::*;
#(
    parameter int NUM_LINES = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_W-1:0]     wdata,
    output logic [NUM_LINES-1:0] cs_en,
    output logic [NUM_LINES-1:0] inv
);
    localparam int HALF = REG_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_en <= '0;
            inv   <= '0;
        end else if (we) begin
            cs_en <= wdata[HALF +: NUM_LINES];
            inv   <= wdata[0 +: NUM_LINES];
        end
    end

endmodule

// File: rtl/csline_level_reg.sv
module csline_level_reg
    import csline_pkg::*;
#(
    parameter int NUM_LINES = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_W-1:0]     wdata,
    output logic [NUM_LINES-1:0] level
);
    localparam int HALF = REG_W / 2;

    logic [NUM_LINES-1:0] raise_bits;
    logic [NUM_LINES-1:0] lower_bits;

    assign raise_bits = wdata[HALF +: NUM_LINES];
    assign lower_bits = wdata[0 +: NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '1;
        end else if (we) begin
            level <= (level & ~lower_bits) | raise_bits;
        end
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(level)); // R10

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line_chk
        AST_RAISE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wdata[HALF + g]) |=> level[g]); // R4
        AST_LOWER_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wdata[g] && !wdata[HALF + g]) |=> !level[g]); // R3
    end

endmodule

// File: rtl/csline_outmux.sv
module csline_outmux #(
    parameter int NUM_LINES = 6
) (
    input  logic [NUM_LINES-1:0] cs_en,
    input  logic [NUM_LINES-1:0] inv,
    input  logic [NUM_LINES-1:0] level,
    output logic [NUM_LINES-1:0] pin
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_pin
        assign pin[g] = cs_en[g] ? (level[g] ^ inv[g]) : inv[g];
    end

endmodule

// File: rtl/csline_ctrl.sv
module csline_ctrl
    import csline_pkg::*;
#(
    parameter int NUM_LINES = 6,
    parameter int ADDR_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [15:0]          wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [15:0]          rd_data,
    output logic                 rd_valid,
    output logic [NUM_LINES-1:0] cs_out
);
    localparam int HALF = REG_W / 2;
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(OFS_FORCE);
    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);

    logic [NUM_LINES-1:0] cs_en;
    logic [NUM_LINES-1:0] inv;
    logic [NUM_LINES-1:0] level;
    logic                 cfg_we;
    logic                 force_we;
    logic [REG_W-1:0]     rd_mux;
    logic [REG_W-1:0]     rd_q;
    rd_state_e            state_q;
    rd_state_e            state_d;

    assign cfg_we   = wr_en && (wr_addr == A_CFG);
    assign force_we = wr_en && (wr_addr == A_FORCE);

    csline_cfg_reg #(.NUM_LINES(NUM_LINES)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (wr_data),
        .cs_en (cs_en),
        .inv   (inv)
    );

    csline_level_reg #(.NUM_LINES(NUM_LINES)) lvl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (force_we),
        .wdata (wr_data),
        .level (level)
    );

    csline_outmux #(.NUM_LINES(NUM_LINES)) mux_i (
        .cs_en (cs_en),
        .inv   (inv),
        .level (level),
        .pin   (cs_out)
    );

    always_comb begin
        rd_mux = '0;
        if (rd_addr == A_CFG) begin
            rd_mux = {HALF'(cs_en), HALF'(inv)};
        end else if (rd_addr == A_LEVEL) begin
            rd_mux = {{HALF{1'b0}}, HALF'(level)};
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: state_d = rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = rd_en ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en) begin
                rd_q <= rd_mux;
            end
        end
    end

    always_comb begin
        rd_valid = (state_q == RD_RESP);
        rd_data  = rd_valid ? rd_q : '0;
    end

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R8
    AST_NO_RESP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R8
    AST_LEVEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_LEVEL) |=> (rd_data[15:8] == 8'h00)); // R7

endmodule

// File: tb/csline_ctrl_tb_top.sv
module csline_ctrl_tb_top;

    localparam int NL = 6;
    localparam logic [7:0] LM = 8'(( 1 << NL) - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [1:0]    rd_addr = '0;
    logic [15:0]   rd_data;
    logic          rd_valid;
    logic [NL-1:0] cs_out;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [7:0] m_en  = 8'h00;
    logic [7:0] m_inv = 8'h00;
    logic [7:0] m_lvl = 8'hFF;

    always #2 clk = ~clk;

    csline_ctrl #(.NUM_LINES(NL), .ADDR_W(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .cs_out   (cs_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_pins();
        return ((m_en & (m_lvl ^ m_inv)) | (~m_en & m_inv)) & LM;
    endfunction

    task automatic do_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd0) begin
            m_en  = d[15:8] & LM;
            m_inv = d[7:0] & LM;
        end else if (a == 2'd1) begin
            m_lvl = ((m_lvl & ~d[7:0]) | d[15:8]) & LM;
        end
    endtask

    task automatic do_read(input logic [1:0] a, output logic [15:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic chk_pins(input string req);
        chk(req, 16'(cs_out), 16'(exp_pins()));
    endtask

    task automatic chk_level(input string req);
        logic [15:0] d; logic v;
        do_read(2'd2, d, v);
        chk(req, {v, d[14:0]}, {1'b1, 7'h00, m_lvl & LM});
        chk(req, {8'h00, d[15:8]}, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_vec++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic v;
        m_lvl = LM;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pins", 16'(cs_out), 16'h0000);
        chk("R1 rd_valid", 16'(rd_valid), 16'h0000);
        do_read(2'd0, d, v);
        chk("R1 cfg", d, 16'h0000);
        chk_level("R1 level");

        // R2 readback masked to implemented lines
        do_write(2'd0, 16'hFFFF);
        do_read(2'd0, d, v);
        chk("R2 cfg all", d, {LM, LM});
        do_write(2'd0, 16'hA5C3);
        do_read(2'd0, d, v);
        chk("R2 cfg pattern", d, {8'hA5 & LM, 8'hC3 & LM});

        // R5/R6 per-line sweep of enable, inversion and level
        for (int n = 0; n < NL; n++) begin
            for (int c = 0; c < 4; c++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    do_write(2'd0, {8'(c[1]) << n, 8'(c[0]) << n});
                    do_write(2'd1, lv[0] ? (16'h0100 << n) : (16'h0001 << n));
                    chk(c[1] ? "R5 pin" : "R6 pin", 16'(cs_out), 16'(exp_pins()));
                    chk_level("R3 level");
                end
            end
        end

        // R3/R4 force pattern sweep with all lines enabled
        for (int k = 0; k < 64; k++) begin
            logic [15:0] pat;
            pat = 16'(k * 40503 + 7);
            if (k % 16 == 0) do_write(2'd0, {8'hFF, 8'(k * 11)});
            do_write(2'd1, pat);
            chk_pins("R3 sweep pins");
            chk_level("R3 sweep level");
        end

        // R4 set and clear together
        do_write(2'd1, 16'h0001);
        do_write(2'd1, 16'h0101);
        chk_level("R4 both bits");
        chk("R4 line0 high", 16'(m_lvl[0]), 16'h0001);

        // R9 writes to status and spare offsets ignored
        do_write(2'd0, 16'h3F15);
        do_write(2'd1, 16'h0A05);
        do_write(2'd2, 16'h00FF);
        do_write(2'd3, 16'hFFFF);
        chk_pins("R9 pins");
        chk_level("R9 level");
        do_read(2'd0, d, v);
        chk("R9 cfg", d, 16'h3F15);

        // R10 config writes leave levels alone
        do_write(2'd0, 16'h00FF);
        do_write(2'd0, 16'h3F00);
        chk_level("R10 level");
        chk_pins("R10 pins");

        // R8 zero offsets and back-to-back reads
        do_read(2'd1, d, v);
        chk("R8 force reads zero", d, 16'h0000);
        do_read(2'd3, d, v);
        chk("R8 spare reads zero", d, 16'h0000);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 2'd0;
        @(negedge clk);
        chk("R8 first valid", 16'(rd_valid), 16'h0001);
        chk("R8 first data", rd_data, 16'h3F00);
        rd_addr = 2'd2;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8 second valid", 16'(rd_valid), 16'h0001);
        chk("R8 second data", rd_data, {8'h00, m_lvl & LM});
        @(negedge clk);
        chk("R8 idle valid", 16'(rd_valid), 16'h0000);
        chk("R8 idle data", rd_data, 16'h0000);

        // R3 restore sequence
        do_write(2'd0, 16'h0000);
        do_write(2'd1, 16'hFF00);
        chk("R3 restore pins", 16'(cs_out), 16'h0000);
        chk_level("R3 restore level");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule